// File: doc/BRIEF.md
# Wired Interrupt Aggregation Controller

This block collects up to 32 interrupt sources into a single wired interrupt line for a parent interrupt controller. Every source owns one bit in a pending-cause register, a mask register and a set-cause alias, so software sees the same bit position for a source in all of them. The cause bit latches when its source is seen. Sensing is either level-high or rising-edge, and one control bit picks the mode for all sources at once.

Software reaches the block through a plain single-cycle register port. A write takes effect at the clock edge where `reg_wr` is high. The read data is combinational on `reg_addr`. To service the block, software reads the cause register and handles the unmasked bits. It acknowledges a bit by writing a 0 to that bit position in the cause register, while writing 1s leaves the other bits alone. To re-raise a source, it writes a 1 to that bit position of the set-cause alias. A control bit that disables message-signalled delivery is stored and read back, but it changes nothing here.

The sensing mode is a two-state machine with the states `SENSE_LEVEL` (the reset state) and `SENSE_RISE`. A control write with bit 3 at 1 moves the machine from `SENSE_LEVEL` to `SENSE_RISE` (transition `arm_edge`). A control write with bit 3 at 0 moves it from `SENSE_RISE` back to `SENSE_LEVEL` (transition `arm_level`). A control write that repeats the current mode leaves the state where it is.

Top module: `irq_gather_top`

## Requirements
- R1: After reset the cause register reads 0x00000000, the mask register reads 0xFFFFFFFF, the control register reads 0x00000000 and `irq_out` is 0.
- R2: In level mode (control bit 3 = 0), a source that is 1 at a clock edge sets its cause bit at that edge. The bit stays set after the source returns to 0.
- R3: In edge mode (control bit 3 = 1), a cause bit is set only when its source is 1 at an edge and was 0 at the edge before. A source held at 1 does not set the bit again after software clears it.
- R4: A write to offset 0x00 clears every cause bit written as 0 and keeps every cause bit written as 1. Reading offset 0x00 returns the cause register in bit positions 0 to 31.
- R5: In level mode, when software clears a cause bit whose source is still 1, the bit reads 0 for one cycle and is set again at the following edge.
- R6: A write to offset 0x08 sets every cause bit written as 1, and bits written as 0 have no effect. Reading offset 0x08 returns 0.
- R7: A write to offset 0x10 loads the mask register, and the mask register reads back at offset 0x10. A mask bit of 1 blocks its source, and `irq_out` is 1 exactly when some cause bit has a mask bit of 0.
- R8: Offset 0x28 is the control register. Bit 3 selects edge mode, and bit 5 is a stored message-delivery disable flag with no other effect. All other bits read 0.
- R9: Reads of any offset other than 0x00, 0x08, 0x10 and 0x28 return 0. Writes to such offsets change no register.
- R10: `irq_out` is registered. It changes at the clock edge after the edge that changed the cause or mask register.
- R11: In edge mode, a rising edge on a source in the same cycle as a cause write that clears that bit leaves the bit set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; all sources are synchronous to it |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | NSRC (32) | Interrupt source lines, one per cause bit |
| reg_wr | input | 1 | Register write strobe, takes effect at the rising clock edge |
| reg_addr | input | AW (8) | Register byte offset for both reads and writes |
| reg_wdata | input | DW (32) | Register write data |
| reg_rdata | output | DW (32) | Combinational read data for `reg_addr` |
| irq_out | output | 1 | Registered wired interrupt to the parent controller |

## Verification
The bench builds the block with its default values: NSRC = 32, AW = 8 and DW = 32. The source count therefore fills the whole data word. This makes bit 31 reachable through a forced cause, and makes the all-ones mask and all-zeros clear match full-width register values. The 8-bit address covers offset 0x28 and a nearby undefined offset. With these values, both sensing states and both transitions between them are exercised, together with the cycle where a software clear meets a live source in each mode.

// File: rtl/irq_gather_pkg.sv
package irq_gather_pkg;
    localparam int OFS_CAUSE = 'h00;
    localparam int OFS_FORCE = 'h08;
    localparam int OFS_MASK  = 'h10;
    localparam int OFS_CTRL  = 'h28;

    localparam int BIT_RISE  = 3;
    localparam int BIT_NOMSG = 5;

    typedef enum logic {
        SENSE_LEVEL = 1'b0,
        SENSE_RISE  = 1'b1
    } sense_e;
endpackage

// File: rtl/irq_gather_sense.sv
module irq_gather_sense
    import irq_gather_pkg::*;
#(
    parameter int NSRC = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_in,
    input  sense_e          sense_mode,
    output logic [NSRC-1:0] hit
);
    logic [NSRC-1:0] src_q;

    for (genvar i = 0; i < NSRC; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) src_q[i] <= 1'b0;
            else        src_q[i] <= src_in[i];
        end
        assign hit[i] = (sense_mode == SENSE_RISE) ? (src_in[i] & ~src_q[i]) : src_in[i];
    end
endmodule

// File: rtl/irq_gather_regs.sv
module irq_gather_regs
    import irq_gather_pkg::*;
#(
    parameter int NSRC = 32,
    parameter int AW   = 8,
    parameter int DW   = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_wr,
    input  logic [AW-1:0]   reg_addr,
    input  logic [DW-1:0]   reg_wdata,
    input  logic [NSRC-1:0] cause_q,
    output logic [NSRC-1:0] keep_bits,
    output logic [NSRC-1:0] force_bits,
    output logic [NSRC-1:0] mask_q,
    output sense_e          sense_mode,
    output logic [DW-1:0]   reg_rdata
);
    localparam logic [AW-1:0] A_CAUSE = AW'(OFS_CAUSE);
    localparam logic [AW-1:0] A_FORCE = AW'(OFS_FORCE);
    localparam logic [AW-1:0] A_MASK  = AW'(OFS_MASK);
    localparam logic [AW-1:0] A_CTRL  = AW'(OFS_CTRL);

    logic   wr_cause, wr_force, wr_mask, wr_ctrl;
    logic   nomsg_q;
    sense_e mode_q, mode_d;

    assign wr_cause = reg_wr && (reg_addr == A_CAUSE);
    assign wr_force = reg_wr && (reg_addr == A_FORCE);
    assign wr_mask  = reg_wr && (reg_addr == A_MASK);
    assign wr_ctrl  = reg_wr && (reg_addr == A_CTRL);

    assign keep_bits  = wr_cause ? reg_wdata[NSRC-1:0] : '1;
    assign force_bits = wr_force ? reg_wdata[NSRC-1:0] : '0;
    assign sense_mode = mode_q;

    // sensing-mode state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= SENSE_LEVEL;
        else        mode_q <= mode_d;
    end

    // transitions arm_edge / arm_level
    always_comb begin
        mode_d = mode_q;
        if (wr_ctrl) begin
            unique case (mode_q)
                SENSE_LEVEL: if (reg_wdata[BIT_RISE])  mode_d = SENSE_RISE;
                SENSE_RISE:  if (!reg_wdata[BIT_RISE]) mode_d = SENSE_LEVEL;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q  <= '1;
            nomsg_q <= 1'b0;
        end else begin
            if (wr_mask) mask_q  <= reg_wdata[NSRC-1:0];
            if (wr_ctrl) nomsg_q <= reg_wdata[BIT_NOMSG];
        end
    end

    // read outputs
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CAUSE: reg_rdata = DW'(cause_q);
            A_MASK:  reg_rdata = DW'(mask_q);
            A_CTRL: begin
                reg_rdata[BIT_RISE]  = (mode_q == SENSE_RISE);
                reg_rdata[BIT_NOMSG] = nomsg_q;
            end
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/irq_gather_cause.sv
module irq_gather_cause
    import irq_gather_pkg::*;
#(
    parameter int NSRC = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] hit,
    input  logic [NSRC-1:0] keep_bits,
    input  logic [NSRC-1:0] force_bits,
    input  logic [NSRC-1:0] mask_q,
    input  sense_e          sense_mode,
    output logic [NSRC-1:0] cause_q,
    output logic            irq_out
);
    logic [NSRC-1:0] hit_term, cause_d;
    logic            irq_q;

    // Level hits yield to a clear (re-sensed next cycle); edge hits survive it.
    assign hit_term = (sense_mode == SENSE_RISE) ? hit : (hit & keep_bits);
    assign cause_d  = (cause_q & keep_bits) | hit_term | force_bits;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cause_q <= '0;
            irq_q   <= 1'b0;
        end else begin
            cause_q <= cause_d;
            irq_q   <= |(cause_q & ~mask_q);
        end
    end

    assign irq_out = irq_q;
endmodule

// File: rtl/irq_gather_top.sv
module irq_gather_top
    import irq_gather_pkg::*;
#(
    parameter int NSRC = 32,
    parameter int AW   = 8,
    parameter int DW   = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_in,
    input  logic            reg_wr,
    input  logic [AW-1:0]   reg_addr,
    input  logic [DW-1:0]   reg_wdata,
    output logic [DW-1:0]   reg_rdata,
    output logic            irq_out
);
    logic [NSRC-1:0] hit_w, keep_w, force_w, mask_w, cause_w;
    sense_e          mode_w;

    irq_gather_sense #(.NSRC(NSRC)) sense_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_in     (src_in),
        .sense_mode (mode_w),
        .hit        (hit_w)
    );

    irq_gather_regs #(.NSRC(NSRC), .AW(AW), .DW(DW)) regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .cause_q    (cause_w),
        .keep_bits  (keep_w),
        .force_bits (force_w),
        .mask_q     (mask_w),
        .sense_mode (mode_w),
        .reg_rdata  (reg_rdata)
    );

    irq_gather_cause #(.NSRC(NSRC)) cause_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .hit        (hit_w),
        .keep_bits  (keep_w),
        .force_bits (force_w),
        .mask_q     (mask_w),
        .sense_mode (mode_w),
        .cause_q    (cause_w),
        .irq_out    (irq_out)
    );
endmodule

// File: rtl/irq_gather_chk.sv
module irq_gather_chk
    import irq_gather_pkg::*;
#(
    parameter int NSRC = 32,
    parameter int AW   = 8,
    parameter int DW   = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NSRC-1:0] src_in,
    input logic            reg_wr,
    input logic [AW-1:0]   reg_addr,
    input logic [DW-1:0]   reg_wdata,
    input logic [DW-1:0]   reg_rdata,
    input logic            irq_out,
    input logic [NSRC-1:0] cause_q,
    input logic [NSRC-1:0] mask_q,
    input sense_e          sense_mode
);
    localparam logic [AW-1:0] A_CAUSE = AW'(OFS_CAUSE);
    localparam logic [AW-1:0] A_FORCE = AW'(OFS_FORCE);
    localparam logic [AW-1:0] A_MASK  = AW'(OFS_MASK);
    localparam logic [AW-1:0] A_CTRL  = AW'(OFS_CTRL);

    logic addr_known;
    assign addr_known = (reg_addr == A_CAUSE) || (reg_addr == A_FORCE) ||
                        (reg_addr == A_MASK)  || (reg_addr == A_CTRL);

    p_level_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sense_mode == SENSE_LEVEL && !(reg_wr && reg_addr == A_CAUSE))
        |=> ((cause_q & $past(src_in)) == $past(src_in)));

    p_clear_all_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_CAUSE && reg_wdata[NSRC-1:0] == '0 &&
         sense_mode == SENSE_LEVEL && src_in == '0)
        |=> (cause_q == '0));

    p_force_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_FORCE)
        |=> ((cause_q & $past(reg_wdata[NSRC-1:0])) == $past(reg_wdata[NSRC-1:0])));

    p_force_reads_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == A_FORCE) |-> (reg_rdata == '0));

    p_mask_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mask_q) == '1) |-> !irq_out);

    p_undef_reads_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_known |-> (reg_rdata == '0));

    p_irq_lag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_out) |-> $past(|(cause_q & ~mask_q)));
endmodule

bind irq_gather_top irq_gather_chk #(.NSRC(NSRC), .AW(AW), .DW(DW)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_in     (src_in),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .irq_out    (irq_out),
    .cause_q    (cause_w),
    .mask_q     (mask_w),
    .sense_mode (mode_w)
);

// File: tb/irq_gather_top_tb_top.sv
`timescale 1ns/1ps
module irq_gather_top_tb_top;
    localparam int NSRC = 32;
    localparam int AW   = 8;
    localparam int DW   = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] src_in = '0;
    logic            reg_wr = 1'b0;
    logic [AW-1:0]   reg_addr = '0;
    logic [DW-1:0]   reg_wdata = '0;
    logic [DW-1:0]   reg_rdata;
    logic            irq_out;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    irq_gather_top #(.NSRC(NSRC), .AW(AW), .DW(DW)) dut_i (
        .clk, .rst_n, .src_in, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata, .irq_out
    );

    typedef struct packed {
        logic        wr;
        logic [7:0]  addr;
        logic [31:0] data;   // write data, or expected read data
        logic [31:0] src;
        logic [7:0]  req;
    } step_t;

    localparam int NSTEP = 24;
    localparam step_t STEPS [NSTEP] = '{
        '{1'b0, 8'h00, 32'h0000_0000, 32'h0000_0000, 8'd1},  // R1 cause
        '{1'b0, 8'h10, 32'hFFFF_FFFF, 32'h0000_0000, 8'd1},  // R1 mask
        '{1'b0, 8'h28, 32'h0000_0000, 32'h0000_0000, 8'd1},  // R1 control
        '{1'b0, 8'h00, 32'h0000_0000, 32'h0000_0005, 8'd2},  // R2 before edge
        '{1'b0, 8'h00, 32'h0000_0005, 32'h0000_0000, 8'd2},  // R2 latched, held
        '{1'b1, 8'h00, 32'hFFFF_FFFE, 32'h0000_0000, 8'd4},
        '{1'b0, 8'h00, 32'h0000_0004, 32'h0000_0000, 8'd4},  // R4 bit0 cleared
        '{1'b1, 8'h08, 32'h8000_0000, 32'h0000_0000, 8'd6},
        '{1'b0, 8'h00, 32'h8000_0004, 32'h0000_0000, 8'd6},  // R6 forced bit31
        '{1'b0, 8'h08, 32'h0000_0000, 32'h0000_0000, 8'd6},  // R6 alias reads 0
        '{1'b1, 8'h28, 32'h0000_0028, 32'h0000_0000, 8'd8},
        '{1'b0, 8'h28, 32'h0000_0028, 32'h0000_0000, 8'd8},  // R8 readback
        '{1'b1, 8'h00, 32'h0000_0000, 32'h0000_0000, 8'd4},
        '{1'b0, 8'h00, 32'h0000_0000, 32'h0000_0010, 8'd3},  // R3 before edge
        '{1'b0, 8'h00, 32'h0000_0010, 32'h0000_0010, 8'd3},  // R3 edge latched
        '{1'b1, 8'h00, 32'h0000_0000, 32'h0000_0010, 8'd3},
        '{1'b0, 8'h00, 32'h0000_0000, 32'h0000_0010, 8'd3},  // R3 held high, no re-set
        '{1'b1, 8'h04, 32'hFFFF_FFFF, 32'h0000_0000, 8'd9},
        '{1'b0, 8'h04, 32'h0000_0000, 32'h0000_0000, 8'd9},  // R9 undefined read
        '{1'b0, 8'h10, 32'hFFFF_FFFF, 32'h0000_0000, 8'd9},  // R9 mask untouched
        '{1'b1, 8'h28, 32'hFFFF_FFFF, 32'h0000_0000, 8'd8},
        '{1'b0, 8'h28, 32'h0000_0028, 32'h0000_0000, 8'd8},  // R8 other bits read 0
        '{1'b1, 8'h28, 32'h0000_0000, 32'h0000_0000, 8'd8},
        '{1'b0, 8'h00, 32'h0000_0000, 32'h0000_0000, 8'd9}   // R9 cause untouched
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_wr(input logic [7:0] a, input logic [31:0] d, input logic [31:0] s);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d; src_in = s;
    endtask

    task automatic do_rd(input logic [7:0] a, input logic [31:0] s,
                         input logic [31:0] exp, input string req);
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = a; src_in = s;
        #1 check(req, reg_rdata, exp);
    endtask

    task automatic do_irq(input logic [31:0] s, input logic exp, input string req);
        @(negedge clk);
        reg_wr = 1'b0; src_in = s;
        #1 check(req, {31'd0, irq_out}, {31'd0, exp});
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1 check("R1 irq_out", {31'd0, irq_out}, 32'd0);

        for (int i = 0; i < NSTEP; i++) begin
            @(negedge clk);
            reg_wr = STEPS[i].wr; reg_addr = STEPS[i].addr;
            reg_wdata = STEPS[i].data; src_in = STEPS[i].src;
            #1;
            if (!STEPS[i].wr)
                check($sformatf("R%0d table step %0d", STEPS[i].req, i), reg_rdata, STEPS[i].data);
        end

        // R5: level clear while source high
        do_rd(8'h00, 32'h4, 32'h0, "R2 pre");
        do_wr(8'h00, 32'h0, 32'h4);
        do_rd(8'h00, 32'h4, 32'h0, "R5 cleared for one cycle");
        do_rd(8'h00, 32'h0, 32'h4, "R5 re-set");
        do_irq(32'h0, 1'b0, "R7 all masked");

        // R7 / R10: unmask and mask again
        do_wr(8'h10, ~32'h4, 32'h0);
        do_irq(32'h0, 1'b0, "R10 lag on unmask");
        do_irq(32'h0, 1'b1, "R7 unmasked cause");
        do_wr(8'h10, 32'hFFFF_FFFF, 32'h0);
        do_irq(32'h0, 1'b1, "R10 lag on mask");
        do_irq(32'h0, 1'b0, "R7 mask blocks");
        do_wr(8'h10, ~32'h4, 32'h0);
        do_irq(32'h0, 1'b0, "R10 lag");
        do_irq(32'h0, 1'b1, "R7 raised");
        do_wr(8'h00, 32'h0, 32'h0);
        do_irq(32'h0, 1'b1, "R10 lag on clear");
        do_irq(32'h0, 1'b0, "R4 clear drops irq");

        // R11: edge mode, rising edge meets a clear
        do_wr(8'h28, 32'h8, 32'h0);
        do_wr(8'h00, 32'h0, 32'h2);
        do_rd(8'h00, 32'h2, 32'h2, "R11 edge survives clear");

        // R8: bit 5 alone, back to level mode
        do_wr(8'h28, 32'h20, 32'h0);
        do_rd(8'h28, 32'h0, 32'h20, "R8 flag only");

        done = 1'b1;
        finish_run();
    end
endmodule